// File: doc/BRIEF.md
# Video controller interrupt port

This block is the processor-facing control port of a tile-based video display processor, together with its interrupt logic. The processor writes bytes to the control port in pairs. The first byte is held. The second byte supplies the upper address bits and a two-bit command kind. When the command kind marks a register write, the held byte is stored into one of sixteen eight-bit configuration registers. The stored address and command kind are presented to the data-port logic. The configuration registers can be read by index for the rendering logic.

Line and frame event pulses arrive from an external timing generator and set sticky pending flags. The interrupt request to the processor is a level. It is the OR of the line flag gated by its enable and the frame flag gated by its enable. The request is therefore re-evaluated whenever software rewrites an enable while a flag is still pending. It stays high until the processor reads the control port. That read returns the frame flag and the sticky status bits, then clears every flag and the first-byte latch.

Top module: `vdp_irq_port`

## Requirements
- R1: After reset, `irq` is 0, `rd_data` is 0, `vram_addr` is 0, `cmd_type` is 0, and every configuration register reads 0 through `cfg_idx`/`cfg_val`.
- R2: A write while no first byte is held loads `wr_data` into `vram_addr[7:0]` and marks a first byte as held.
- R3: A write while a first byte is held loads `wr_data[5:0]` into `vram_addr[13:8]` and `wr_data[7:6]` into `cmd_type`, and it clears the held mark.
- R4: When that second byte has `wr_data[7:6]` = 2'b10, the configuration register numbered `wr_data[3:0]` takes the held byte (`vram_addr[7:0]`). Other command kinds leave every register unchanged.
- R5: During a cycle with `rd_en` high, `rd_data[7]` is the frame pending flag and `rd_data[6:0]` are the sticky status bits, which are set by pulses on `sts_set`.
- R6: A read clears the line flag, the frame flag, the status bits and the held first-byte mark, so `irq` is 0 on the following cycle unless an event arrived with the read.
- R7: A line event sets the line flag. `irq` is high on the next cycle if bit 4 of register 0 is 1.
- R8: A frame event sets the frame flag. `irq` is high on the next cycle if bit 5 of register 1 is 1.
- R9: `irq` equals (line flag AND register 0 bit 4) OR (frame flag AND register 1 bit 5). It rises or falls as soon as a write changes either enable, and it stays high until a read or an enable change.
- R10: An event or a status pulse in the same cycle as a read remains set after the read.
- R11: A write in the same cycle as a read is handled as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-port byte write strobe |
| wr_data | input | 8 | Control-port write byte |
| rd_en | input | 1 | Control-port read strobe |
| rd_data | output | 8 | Status byte: frame flag in bit 7, status bits below |
| line_evt | input | 1 | Line event pulse from timing generator |
| frame_evt | input | 1 | Frame event pulse from timing generator |
| sts_set | input | 7 | Pulses that set sticky status bits |
| cfg_idx | input | 4 | Configuration register select for readout |
| cfg_val | output | 8 | Selected configuration register value |
| vram_addr | output | 14 | Assembled address for the data port |
| cmd_type | output | 2 | Command kind from the second byte |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
The assertions check the following on every cycle: a read without a coincident event drops `irq`, an enabled event raises it on the next cycle, the request holds while neither port is touched, and the first and second bytes land in the correct address fields. Only the bench's scenarios show that register contents follow the command kind, that an enable rewrite lowers or restores a request while another source keeps it up, and that reads and writes or events in the same cycle resolve as required. Those scenarios are checked against a reference model kept in the bench.

// File: rtl/vdp_irq_port.sv
module vdp_irq_port #(
  parameter int DW     = 8,
  parameter int ADDR_W = 14,
  parameter int NREG   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic              line_evt,
  input  logic              frame_evt,
  input  logic [DW-2:0]     sts_set,
  input  logic [3:0]        cfg_idx,
  output logic [DW-1:0]     cfg_val,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [1:0]        cmd_type,
  output logic              irq
);
  localparam int IW   = $clog2(NREG);
  localparam int HI_W = ADDR_W - DW;

  logic [DW-1:0] regs [NREG];
  logic [DW-2:0] sts;
  logic          line_pend, frame_pend, pend_q;
  logic          en_line, en_frame, second;
  logic [1:0]    kind;

  assign en_line  = regs[0][4];
  assign en_frame = regs[1][5];
  assign irq      = (line_pend & en_line) | (frame_pend & en_frame);
  assign rd_data  = {frame_pend, sts};
  assign cfg_val  = regs[cfg_idx[IW-1:0]];
  assign second   = pend_q & ~rd_en;
  assign kind     = wr_data[DW-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      sts        <= '0;
      line_pend  <= 1'b0;
      frame_pend <= 1'b0;
      pend_q     <= 1'b0;
      vram_addr  <= '0;
      cmd_type   <= '0;
    end else begin
      sts        <= (rd_en ? '0 : sts) | sts_set;
      line_pend  <= (line_pend & ~rd_en) | line_evt;
      frame_pend <= (frame_pend & ~rd_en) | frame_evt;
      if (wr_en) begin
        if (second) begin
          vram_addr[ADDR_W-1:DW] <= wr_data[HI_W-1:0];
          cmd_type               <= kind;
          pend_q                 <= 1'b0;
          if (kind == 2'b10) regs[wr_data[IW-1:0]] <= vram_addr[DW-1:0];
        end else begin
          vram_addr[DW-1:0] <= wr_data;
          pend_q            <= 1'b1;
        end
      end else if (rd_en) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

module vdp_irq_port_chk #(
  parameter int DW     = 8,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic              line_evt,
  input logic              frame_evt,
  input logic              irq,
  input logic [ADDR_W-1:0] vram_addr,
  input logic [1:0]        cmd_type,
  input logic              pend_q,
  input logic              en_line,
  input logic              en_frame
);
  // R6
  read_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !line_evt && !frame_evt |=> !irq);
  // R7
  line_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt && en_line && !wr_en |=> irq);
  // R8
  frame_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && en_frame && !wr_en |=> irq);
  // R9
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_en && !wr_en |=> irq);
  // R2
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !pend_q |=> vram_addr[DW-1:0] == $past(wr_data) && pend_q);
  // R3
  second_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && pend_q && !rd_en |=> cmd_type == $past(wr_data[DW-1 -: 2]) && !pend_q);
endmodule

bind vdp_irq_port vdp_irq_port_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_vdp_irq_port.sv
module test_vdp_irq_port;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, line_evt = 0, frame_evt = 0;
  logic [7:0] wr_data = 0, rd_data, cfg_val;
  logic [6:0] sts_set = 0;
  logic [3:0] cfg_idx = 0;
  logic [13:0] vram_addr;
  logic [1:0] cmd_type;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vdp_irq_port i_vdp_irq_port (.*);

  logic [7:0] m_regs [16];
  logic [6:0] m_sts;
  logic m_line, m_frame, m_latch;
  logic [13:0] m_addr;
  logic [1:0] m_type;

  function automatic logic exp_irq();
    return (m_line & m_regs[0][4]) | (m_frame & m_regs[1][5]);
  endfunction
  function automatic logic [7:0] exp_rd();
    return {m_frame, m_sts};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic w, input logic [7:0] d, input logic r,
                       input logic le, input logic fe, input logic [6:0] ss);
    if (w) begin
      if (m_latch && !r) begin
        m_addr[13:8] = d[5:0];
        m_type = d[7:6];
        m_latch = 0;
        if (d[7:6] == 2'b10) m_regs[d[3:0]] = m_addr[7:0];
      end else begin
        m_addr[7:0] = d;
        m_latch = 1;
      end
    end else if (r) m_latch = 0;
    m_sts   = (r ? 7'd0 : m_sts) | ss;
    m_line  = (m_line & ~r) | le;
    m_frame = (m_frame & ~r) | fe;
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic le, input logic fe, input logic [6:0] ss);
    wr_en = w; wr_data = d; rd_en = r; line_evt = le; frame_evt = fe; sts_set = ss;
    #1;
    if (r) chk(rd_data, exp_rd(), "R5 status byte");
    @(posedge clk);
    model(w, d, r, le, fe, ss);
    @(negedge clk);
    wr_en = 0; rd_en = 0; line_evt = 0; frame_evt = 0; sts_set = 0;
    cfg_idx = 4'($urandom_range(0, 15));
    #1;
    chk(irq, exp_irq(), "R9 irq level");
    chk(vram_addr, m_addr, "R3 address");
    chk(cmd_type, m_type, "R3 command kind");
    chk(cfg_val, m_regs[cfg_idx], "R4 register file");
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [7:0] v);
    step(1, v, 0, 0, 0, 0);
    step(1, {4'b1000, idx}, 0, 0, 0, 0);
  endtask

  task automatic peek(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    cfg_idx = idx; #1;
    chk(cfg_val, exp, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_regs[i] = 0;
    m_sts = 0; m_line = 0; m_frame = 0; m_latch = 0; m_addr = 0; m_type = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(irq, 0, "R1 irq after reset");
    chk(rd_data, 0, "R1 status after reset");
    chk(vram_addr, 0, "R1 address after reset");
    chk(cmd_type, 0, "R1 kind after reset");
    peek(4'd0, 8'h00, "R1 reg0 after reset");
    peek(4'd1, 8'h00, "R1 reg1 after reset");

    step(1, 8'h10, 0, 0, 0, 0);
    chk(vram_addr[7:0], 8'h10, "R2 first byte");
    step(1, 8'h80, 0, 0, 0, 0);
    peek(4'd0, 8'h10, "R4 reg0 written");
    chk(cmd_type, 2'b10, "R3 kind register write");

    step(1, 8'h55, 0, 0, 0, 0);
    step(1, 8'h43, 0, 0, 0, 0);
    peek(4'd3, 8'h00, "R4 non-register kind ignored");
    chk(vram_addr, 14'h0355, "R3 address assembled");

    step(0, 0, 0, 1, 0, 0);
    chk(irq, 1, "R7 enabled line event");
    wreg(4'd0, 8'h00);
    chk(irq, 0, "R9 enable cleared drops irq");
    wreg(4'd0, 8'h10);
    chk(irq, 1, "R9 enable set restores irq");
    step(0, 0, 0, 0, 0, 0);
    chk(irq, 1, "R9 irq held");

    wreg(4'd1, 8'h20);
    step(0, 0, 0, 0, 1, 0);
    chk(irq, 1, "R8 frame event");
    wreg(4'd0, 8'h00);
    chk(irq, 1, "R9 frame source keeps irq");
    step(0, 0, 0, 0, 0, 7'h05);
    cfg_idx = 0;
    rd_en = 1; #1;
    chk(rd_data, 8'h85, "R5 frame bit and status");
    step(0, 0, 1, 0, 0, 0);
    chk(irq, 0, "R6 read drops irq");
    chk(rd_data, 8'h00, "R6 read clears flags");

    wreg(4'd1, 8'h00);
    step(0, 0, 0, 0, 1, 0);
    chk(irq, 0, "R8 disabled frame event");
    chk(rd_data[7], 1, "R8 frame flag set");

    step(0, 0, 1, 0, 1, 7'h02);
    chk(rd_data, 8'h82, "R10 event with read kept");

    step(1, 8'h33, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(1, 8'h82, 0, 0, 0, 0);
    chk(vram_addr[7:0], 8'h82, "R6 read clears first-byte latch");
    peek(4'd2, 8'h00, "R6 no register write after read");
    step(1, 8'h00, 0, 0, 0, 0);

    step(1, 8'h77, 0, 0, 0, 0);
    step(1, 8'h8F, 1, 0, 0, 0);
    chk(vram_addr[7:0], 8'h8F, "R11 write with read is first byte");
    peek(4'd15, 8'h00, "R11 no register write");
    step(1, 8'h41, 0, 0, 0, 0);
    chk(cmd_type, 2'b01, "R11 next write is second byte");

    for (int n = 0; n < 3000; n++) begin
      logic w, r, le, fe;
      logic [7:0] d;
      logic [6:0] ss;
      w  = ($urandom_range(0, 9) < 4);
      r  = ($urandom_range(0, 9) == 0);
      le = ($urandom_range(0, 9) == 0);
      fe = ($urandom_range(0, 19) == 0);
      ss = ($urandom_range(0, 19) == 0) ? 7'($urandom) : 7'd0;
      d  = 8'($urandom);
      if ($urandom_range(0, 2) == 0) d[7:6] = 2'b10;
      if ($urandom_range(0, 3) == 0) d = {3'b000, 1'($urandom), 4'h0} | (d & 8'hEF);
      step(w, d, r, le, fe, ss);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule